// File: doc/BRIEF.md
# SPI Flash Word Reader

This block is a register-driven SPI master that fetches one 32-bit word from a serial flash device. Software programs a timing/control register, an address register and an opcode register through a simple register port. It then writes the control register again with its go bit set. The block drops chip select and sends the opcode and then the address, most significant bit first. It clocks in 32 data bits and stores them in a read-only data register.

Each part of the SPI waveform has its own clock count in system clocks: select-to-clock setup, clock high, clock low, clock-to-deselect hold, and the deselected gap at the end. The go bit is the only completion indication. It stays set for the whole transfer and clears itself once the gap has elapsed. Software that still sees it set after its own time limit treats the read as timed out. An optional ready gate holds back the start of the frame until the flash signals ready.

Top module: `spi_word_fetch`

## Requirements
- R1: After reset the control register reads 0x00132222. That is setup=2 in bits [3:0], high=2 in [7:4], low=2 in [11:8], hold=2 in [15:12], gap=3 in [19:16], command select=1 in [21:20], ready-gate=0 in bit 22 and go=0 in bit 31. The opcode register reads 0x03, the address and data registers read 0, chip select is high and SCLK is low.
- R2: The register select codes are 0 for control, 1 for address (the low 24 bits are kept and the rest read 0), 2 for data and 3 for opcode (the low 8 bits are kept). Read data is registered and appears one clock after the select. Writes to the data register have no effect.
- R3: A read frame holds chip select low for 64 SCLK pulses. It sends the opcode register's 8 bits and then the 24 address bits, most significant bit first, and captures the following 32 bits from MISO on rising SCLK, first bit into bit 31. MOSI never changes while SCLK is high, and SCLK idles low.
- R4: From chip select falling to the first rising SCLK takes setup clocks. Each high pulse lasts high clocks, and each low time between pulses lasts low clocks. From the last falling SCLK to chip select rising takes hold clocks. A field value of 0 behaves as 1.
- R5: The go bit reads 1 for exactly 1+S+64H+63L+D+G consecutive clocks after the write that sets it, where S, H, L, D and G are the effective phase counts. Chip select is back high for G clocks before go clears.
- R6: If go is set with a command select other than 1, no frame is issued, go reads 1 for one clock only, and the data register is unchanged.
- R7: With the ready-gate bit set and the ready input low, chip select stays high and go stays set. With the gate bit clear, the ready input has no effect.
- R8: Any register write while go is set is dropped, including a write in the very clock where go clears. The next write is accepted.
- R9: The data register changes only at the end of a read frame.
- R10: The opcode sent is whatever the opcode register holds, so it can be reprogrammed for a different flash vendor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for writes |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | 32 | Registered read data |
| flash_ready | input | 1 | Flash ready indication for the ready gate |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Transfer completion, where go clears itself, and a software register write can fall on the same clock edge. The bench works out the exact completion edge from the programmed phase counts and places an address write on that edge. It then reads the address back and expects the old value. An address write issued one clock later must land. A flash model on the pins checks opcode, address and returned data for a table of timing settings, and edge-run counters check every phase width.

// File: rtl/spi_wf_pkg.sv
package spi_wf_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_OPC  = 2'd3;
  localparam logic [1:0] CMD_READ = 2'd1;

  // index of each timing field inside the packed timing vector
  localparam int K_SETUP = 0;
  localparam int K_HIGH  = 1;
  localparam int K_LOW   = 2;
  localparam int K_HOLD  = 3;
  localparam int K_GAP   = 4;
  localparam int N_PHASE = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_HOLD, ST_GAP
  } wf_state_t;
endpackage

// File: rtl/spi_wf_timer.sv
module spi_wf_timer #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [PH_W-1:0] len_i,
  output logic            expire_o
);
  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (len_i == '0) ? '0 : len_i - PH_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - PH_W'(1);
    end
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/spi_wf_regs.sv
module spi_wf_regs
  import spi_wf_pkg::*;
#(
  parameter int PH_W   = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int OP_W   = 8,
  parameter int REG_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_sel_i,
  input  logic [REG_W-1:0]         wr_data_i,
  input  logic [1:0]               rd_sel_i,
  output logic [REG_W-1:0]         rd_data_o,
  input  logic                     done_i,
  input  logic                     cap_en_i,
  input  logic [DATA_W-1:0]        cap_data_i,
  output logic                     go_o,
  output logic [1:0]               cmd_o,
  output logic                     wait_o,
  output logic [N_PHASE*PH_W-1:0]  tim_o,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [OP_W-1:0]          op_o
);
  localparam int TIM_W = N_PHASE * PH_W;
  localparam int CF_W  = TIM_W + 3;
  localparam logic [CF_W-1:0] CTRL_RST =
    {1'b0, CMD_READ, PH_W'(3), PH_W'(2), PH_W'(2), PH_W'(2), PH_W'(2)};

  logic [CF_W-1:0]   ctrl_q;
  logic              go_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] data_q;
  logic [REG_W-1:0]  ctrl_view;
  logic              accept;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i;
  assign accept = wr_en_i && !go_q;

  always_comb begin
    ctrl_view            = '0;
    ctrl_view[CF_W-1:0]  = ctrl_q;
    ctrl_view[REG_W-1]   = go_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RST;
      go_q      <= 1'b0;
      addr_q    <= '0;
      op_q      <= OP_W'(8'h03);
      data_q    <= '0;
      rd_data_o <= '0;
    end else begin
      if (accept && wr_sel_i == SEL_CTRL) begin
        ctrl_q <= wr_data_i[CF_W-1:0];
        go_q   <= wr_data_i[REG_W-1];
      end else if (done_i) begin
        go_q <= 1'b0;
      end
      if (accept && wr_sel_i == SEL_ADDR) addr_q <= wr_data_i[ADDR_W-1:0];
      if (accept && wr_sel_i == SEL_OPC)  op_q   <= wr_data_i[OP_W-1:0];
      if (cap_en_i) data_q <= cap_data_i;
      case (rd_sel_i)
        SEL_CTRL: rd_data_o <= ctrl_view;
        SEL_ADDR: rd_data_o <= REG_W'(addr_q);
        SEL_DATA: rd_data_o <= REG_W'(data_q);
        default:  rd_data_o <= REG_W'(op_q);
      endcase
    end
  end

  assign go_o   = go_q;
  assign tim_o  = ctrl_q[TIM_W-1:0];
  assign cmd_o  = ctrl_q[TIM_W+1:TIM_W];
  assign wait_o = ctrl_q[TIM_W+2];
  assign addr_o = addr_q;
  assign op_o   = op_q;

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (go_q && wr_en_i && wr_sel_i == SEL_ADDR) |=> $stable(addr_q)); // R8
  AST_DATA_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !cap_en_i |=> $stable(data_q)); // R9
  AST_GO_CLEARS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(go_q) |-> $past(done_i)); // R5
endmodule

// File: rtl/spi_wf_engine.sv
module spi_wf_engine
  import spi_wf_pkg::*;
#(
  parameter int PH_W   = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int OP_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go_i,
  input  logic [1:0]              cmd_i,
  input  logic                    wait_i,
  input  logic                    ready_i,
  input  logic [N_PHASE*PH_W-1:0] tim_i,
  input  logic [OP_W-1:0]         op_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    miso_i,
  output logic                    sclk_o,
  output logic                    cs_n_o,
  output logic                    mosi_o,
  output logic                    done_o,
  output logic                    cap_en_o,
  output logic [DATA_W-1:0]       cap_data_o
);
  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  wf_state_t          state_q, state_n;
  logic [FRAME_W-1:0] sreg_q;
  logic [BIT_W-1:0]   bit_q;
  logic               sclk_q, cs_n_q, mosi_q;
  logic               load, expire, last;
  logic [PH_W-1:0]    len;
  logic [PH_W-1:0]    t_setup, t_high, t_low, t_hold, t_gap;

  assign t_setup = tim_i[K_SETUP*PH_W +: PH_W];
  assign t_high  = tim_i[K_HIGH*PH_W  +: PH_W];
  assign t_low   = tim_i[K_LOW*PH_W   +: PH_W];
  assign t_hold  = tim_i[K_HOLD*PH_W  +: PH_W];
  assign t_gap   = tim_i[K_GAP*PH_W   +: PH_W];
  assign last    = (bit_q == BIT_W'(FRAME_W));

  spi_wf_timer #(.PH_W(PH_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .len_i    (len),
    .expire_o (expire)
  );

  always_comb begin
    state_n  = state_q;
    load     = 1'b0;
    len      = '0;
    done_o   = 1'b0;
    cap_en_o = 1'b0;
    case (state_q)
      ST_IDLE: if (go_i) begin
        if (cmd_i != CMD_READ) begin
          done_o = 1'b1;
        end else if (!wait_i || ready_i) begin
          state_n = ST_SETUP; load = 1'b1; len = t_setup;
        end
      end
      ST_SETUP: if (expire) begin
        state_n = ST_HIGH; load = 1'b1; len = t_high;
      end
      ST_HIGH: if (expire) begin
        load = 1'b1;
        if (last) begin
          state_n = ST_HOLD; len = t_hold; cap_en_o = 1'b1;
        end else begin
          state_n = ST_LOW; len = t_low;
        end
      end
      ST_LOW: if (expire) begin
        state_n = ST_HIGH; load = 1'b1; len = t_high;
      end
      ST_HOLD: if (expire) begin
        state_n = ST_GAP; load = 1'b1; len = t_gap;
      end
      ST_GAP: if (expire) begin
        state_n = ST_IDLE; done_o = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sreg_q  <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      sclk_q  <= (state_n == ST_HIGH);
      cs_n_q  <= (state_n == ST_IDLE) || (state_n == ST_GAP);
      if (state_q == ST_IDLE && state_n == ST_SETUP) begin
        sreg_q <= {op_i, addr_i, DATA_W'(0)};
        bit_q  <= '0;
        mosi_q <= op_i[OP_W-1];
      end
      if (state_n == ST_HIGH && state_q != ST_HIGH) begin
        sreg_q <= {sreg_q[FRAME_W-2:0], miso_i};
        bit_q  <= bit_q + BIT_W'(1);
      end
      if (state_q == ST_HIGH && state_n == ST_LOW)  mosi_q <= sreg_q[FRAME_W-1];
      if (state_q == ST_HIGH && state_n == ST_HOLD) mosi_q <= 1'b0;
    end
  end

  assign cap_data_o = sreg_q[DATA_W-1:0];
  assign sclk_o     = sclk_q;
  assign cs_n_o     = cs_n_q;
  assign mosi_o     = mosi_q;

  AST_CLK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> !cs_n_q); // R3
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> $stable(mosi_q)); // R3
  AST_FRAME_UNDER_GO: assert property (@(posedge clk) disable iff (rst)
    !cs_n_q |-> go_i); // R5
  AST_WAIT_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && go_i && cmd_i == CMD_READ && wait_i && !ready_i)
      |=> cs_n_q); // R7
  AST_REJECT_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && go_i && cmd_i != CMD_READ) |=> (cs_n_q && !go_i)); // R6
endmodule

// File: rtl/spi_word_fetch.sv
module spi_word_fetch
  import spi_wf_pkg::*;
#(
  parameter int PH_W   = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int OP_W   = 8,
  parameter int REG_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_wr_sel,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic [1:0]       reg_rd_sel,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             flash_ready,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int TIM_W = N_PHASE * PH_W;

  logic              go, wait_en, done, cap_en;
  logic [1:0]        cmd;
  logic [TIM_W-1:0]  tim;
  logic [ADDR_W-1:0] addr;
  logic [OP_W-1:0]   opc;
  logic [DATA_W-1:0] cap_data;

  spi_wf_regs #(
    .PH_W(PH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(OP_W), .REG_W(REG_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (reg_wr_en),
    .wr_sel_i   (reg_wr_sel),
    .wr_data_i  (reg_wr_data),
    .rd_sel_i   (reg_rd_sel),
    .rd_data_o  (reg_rd_data),
    .done_i     (done),
    .cap_en_i   (cap_en),
    .cap_data_i (cap_data),
    .go_o       (go),
    .cmd_o      (cmd),
    .wait_o     (wait_en),
    .tim_o      (tim),
    .addr_o     (addr),
    .op_o       (opc)
  );

  spi_wf_engine #(
    .PH_W(PH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(OP_W)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .go_i       (go),
    .cmd_i      (cmd),
    .wait_i     (wait_en),
    .ready_i    (flash_ready),
    .tim_i      (tim),
    .op_i       (opc),
    .addr_i     (addr),
    .miso_i     (spi_miso),
    .sclk_o     (spi_sclk),
    .cs_n_o     (spi_cs_n),
    .mosi_o     (spi_mosi),
    .done_o     (done),
    .cap_en_o   (cap_en),
    .cap_data_o (cap_data)
  );
endmodule

// File: tb/spi_word_fetch_bench.sv
`timescale 1ns/1ps
module spi_word_fetch_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        ready = 1'b0;
  logic        sclk, cs_n, mosi;
  logic        miso = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  spi_word_fetch u_spi_word_fetch (
    .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_sel(wr_sel),
    .reg_wr_data(wr_data), .reg_rd_sel(rd_sel), .reg_rd_data(rd_data),
    .flash_ready(ready), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  function automatic logic [31:0] fdata(input logic [23:0] a);
    return {~a[7:0], a} ^ 32'h5A3C_96E1;
  endfunction

  function automatic int eff(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  function automatic logic [31:0] cw(input int s, h, l, hd, g,
                                     input logic [1:0] cmd, input logic wt, go);
    return {go, 8'b0, wt, cmd, 4'(g), 4'(hd), 4'(l), 4'(h), 4'(s)};
  endfunction

  // flash model
  int          fcnt = 0;
  logic [31:0] fin = '0;
  logic [7:0]  f_op = '0;
  logic [23:0] f_addr = '0;
  always @(negedge cs_n or posedge sclk) begin
    if (sclk && !cs_n) begin
      fin = {fin[30:0], mosi};
      fcnt = fcnt + 1;
      if (fcnt == 32) begin f_op = fin[31:24]; f_addr = fin[23:0]; end
    end else begin
      fcnt = 0;
    end
  end
  always @(negedge sclk) begin
    if (!cs_n && fcnt >= 32 && fcnt < 64) miso = fdata(f_addr)[63 - fcnt];
  end

  // waveform run monitor
  logic pcs = 1'b1, psck = 1'b0;
  int run = 0, m_setup = 0, m_hold = 0, pulses = 0, frames = 0;
  int hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0;
  always @(negedge clk) begin
    if (cs_n === pcs && sclk === psck) begin
      run = run + 1;
    end else begin
      if (!pcs && !psck && sclk && pulses == 0) m_setup = run;
      else if (!pcs && psck) begin
        pulses = pulses + 1;
        if (run < hi_min) hi_min = run;
        if (run > hi_max) hi_max = run;
      end else if (!pcs && !psck && sclk) begin
        if (run < lo_min) lo_min = run;
        if (run > lo_max) lo_max = run;
      end else if (!pcs && !psck && cs_n) m_hold = run;
      if (pcs && cs_n === 1'b0) begin
        frames = frames + 1; pulses = 0;
        hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
      end
      run = 1;
    end
    pcs = cs_n; psck = sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (rd_data[31]) n++;
      else break;
    end
  endtask

  // s h l hold gap opcode address
  localparam logic [51:0] VECS [5] = '{
    {4'd2,  4'd2, 4'd2, 4'd2, 4'd3,  8'h03, 24'h123456},
    {4'd1,  4'd1, 4'd1, 4'd1, 4'd1,  8'h0B, 24'hFFFFFF},
    {4'd0,  4'd0, 4'd0, 4'd0, 4'd0,  8'h03, 24'h000000},
    {4'd5,  4'd3, 4'd1, 4'd4, 4'd7,  8'h13, 24'h800001},
    {4'd15, 4'd1, 4'd3, 4'd2, 4'd15, 8'hA5, 24'h5A5A5A}
  };

  initial begin
    logic [31:0] v, v2;
    int n, fr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 cs_n idle", 32'(cs_n), 32'd1);
    chk("R1 sclk idle", 32'(sclk), 32'd0);
    rd(2'd0, v); chk("R1 control reset", v, 32'h0013_2222);
    rd(2'd3, v); chk("R1 opcode reset", v, 32'h03);
    rd(2'd1, v); chk("R1 address reset", v, 32'h0);
    rd(2'd2, v); chk("R1 data reset", v, 32'h0);

    // R2 field widths and read-only data
    wr(2'd2, 32'hDEAD_BEEF); rd(2'd2, v); chk("R2 data write ignored", v, 32'h0);
    wr(2'd1, 32'hFFAB_CDEF); rd(2'd1, v); chk("R2 address width", v, 32'h00AB_CDEF);
    wr(2'd3, 32'h1234_5677); rd(2'd3, v); chk("R2 opcode width", v, 32'h77);

    // table of timing settings: R3 R4 R5 R10, ready input low (R7 gate clear)
    for (int i = 0; i < 5; i++) begin
      int s, h, l, hd, g, t;
      logic [7:0] op; logic [23:0] ad;
      s = VECS[i][51:48]; h = VECS[i][47:44]; l = VECS[i][43:40];
      hd = VECS[i][39:36]; g = VECS[i][35:32];
      op = VECS[i][31:24]; ad = VECS[i][23:0];
      t = eff(s) + 64*eff(h) + 63*eff(l) + eff(hd) + eff(g);
      rd_sel = 2'd0;
      wr(2'd0, cw(s, h, l, hd, g, 2'd1, 1'b0, 1'b0));
      wr(2'd1, {8'h0, ad});
      wr(2'd3, {24'h0, op});
      wr(2'd0, cw(s, h, l, hd, g, 2'd1, 1'b0, 1'b1));
      count_busy(n);
      chk("R5 go duration", n, 32'(t + 1));
      chk("R10 opcode sent", {24'h0, f_op}, {24'h0, op});
      chk("R3 address sent", {8'h0, f_addr}, {8'h0, ad});
      chk("R3 pulse count", pulses, 32'd64);
      rd(2'd2, v); chk("R3 data captured", v, fdata(ad));
      chk("R4 setup", m_setup, 32'(eff(s)));
      chk("R4 high min", hi_min, 32'(eff(h)));
      chk("R4 high max", hi_max, 32'(eff(h)));
      chk("R4 low min", lo_min, 32'(eff(l)));
      chk("R4 low max", lo_max, 32'(eff(l)));
      chk("R4 hold", m_hold, 32'(eff(hd)));
    end

    // R6 non-read command select
    rd(2'd2, v2);
    fr = frames;
    rd_sel = 2'd0;
    wr(2'd0, cw(2, 2, 2, 2, 3, 2'd2, 1'b0, 1'b1));
    count_busy(n);
    chk("R6 go one clock", n, 32'd1);
    chk("R6 no frame", frames, fr);
    rd(2'd2, v); chk("R6 data unchanged", v, v2);

    // R7 ready gate
    wr(2'd1, 32'h0000_0A0A);
    fr = frames;
    rd_sel = 2'd0;
    wr(2'd0, cw(1, 1, 1, 1, 1, 2'd1, 1'b1, 1'b1));
    repeat (20) @(negedge clk);
    chk("R7 held no frame", frames, fr);
    chk("R7 go still set", 32'(rd_data[31]), 32'd1);
    ready = 1'b1;
    count_busy(n);
    ready = 1'b0;
    chk("R7 frame after ready", frames, fr + 1);
    rd(2'd2, v); chk("R7 data", v, fdata(24'h000A0A));

    // R8 writes while busy, including on the completion edge
    wr(2'd1, 32'h0000_1111);
    rd_sel = 2'd0;
    wr(2'd0, cw(2, 2, 2, 2, 3, 2'd1, 1'b0, 1'b1));
    repeat (10) @(negedge clk);
    wr(2'd1, 32'h0000_2222);
    repeat (261 - 11) @(negedge clk);
    wr(2'd1, 32'h0000_3333);
    rd(2'd0, v); chk("R8 go cleared", 32'(v[31]), 32'd0);
    rd(2'd1, v); chk("R8 busy writes dropped", v, 32'h0000_1111);
    chk("R8 frame address", {8'h0, f_addr}, 32'h0000_1111);
    wr(2'd1, 32'h0000_4444);
    rd(2'd1, v); chk("R8 next write lands", v, 32'h0000_4444);
    rd(2'd2, v); chk("R9 data from frame", v, fdata(24'h001111));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule